// File: doc/BRIEF.md
# Rate-Half Systematic Trellis Encoder

This block turns a serial stream of information bits into a stream of two-bit coded symbols, one symbol for every bit it accepts. The first bit of each symbol repeats the information bit. The second bit is a parity bit: the inverse of the exclusive-or of the current bit and the bit accepted just before it. This choice limits every symbol to two legal successors, and a later decoding stage relies on that.

The encoder sits after an outer code and before the modulator. A one-cycle frame start pulse returns the trellis to its initial state and loads a frame length, which can be set at run time up to 1200 bits. When that many bits have been accepted, the encoder flags the last symbol and starts the next frame from the initial state on its own. No tail or termination symbols are added. The input takes bits through a valid/ready handshake, and the output presents symbols through a valid/ready handshake with a single output register.

Top module: `trellis_half_enc`

## Requirements
- R1: Each bit accepted (`in_valid` and `in_ready` high at a rising edge) produces exactly one symbol. That symbol appears on `out_sym` with `out_valid` high after that same edge. `out_valid` falls after an edge where it was high, `out_ready` was high and no new bit was accepted.
- R2: The output is systematic: `out_sym[1]` equals the accepted information bit.
- R3: The first bit of a frame is encoded from the initial state. Input 1 gives `out_sym` = 2'b10 and input 0 gives 2'b01. A frame begins after reset, on a bit accepted with or after `frame_start`, and on the bit that follows a frame's last bit.
- R4: Inside a frame, when the previous accepted bit was 0, input 0 gives 2'b01 and input 1 gives 2'b10.
- R5: Inside a frame, when the previous accepted bit was 1, input 0 gives 2'b00 and input 1 gives 2'b11.
- R6: A bit accepted in the same cycle as `frame_start` is the first bit of the new frame. A `frame_start` with no bit accepted clears the state for the next bit that is accepted. Frame start with bits 1,0,0,1,1,0,0,1 yields 10,00,01,10,11,00,01,10.
- R7: `frame_len` is sampled on `frame_start`. A value of 0 or above 1200 means 1200. The symbol of the L-th bit of a frame carries `out_last` = 1, and every other symbol carries 0. Bit L+1 starts a new frame of the same length. No extra symbols are emitted.
- R8: While `out_valid` is high and `out_ready` is low, `out_sym` and `out_last` hold, `in_ready` is low, and `in_bit` is ignored.
- R9: After reset `out_valid` is 0, `in_ready` is 1, and the frame length is 1200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: restart the trellis and load `frame_len` |
| frame_len | input | 11 | Frame length in bits (0 or >1200 selects 1200) |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| out_valid | output | 1 | `out_sym` holds a symbol |
| out_sym | output | 2 | {information bit, parity bit} |
| out_last | output | 1 | Symbol belongs to the last bit of a frame |
| out_ready | input | 1 | Consumer takes the symbol this cycle |

## Verification
The assertions assume that the consumer and the producer follow the handshake. Input bits count only at edges where `in_ready` is high, and `frame_start` is a single-cycle event whose `frame_len` is valid in that cycle. The stimulus drives every input at the falling edge and changes it only there. Its random part draws valid, ready, frame start and short frame lengths, so stalls, same-cycle restarts and automatic frame wraps all occur. Directed runs cover the sample pattern, a full 1200-bit default frame and a zero length, which is read as 1200.

// File: rtl/trellis_half_enc.sv
module trellis_half_enc #(
  parameter int MAX_FRAME = 1200,
  localparam int LW = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [LW-1:0] frame_len,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          in_ready,
  output logic          out_valid,
  output logic [1:0]    out_sym,
  output logic          out_last,
  input  logic          out_ready
);
  localparam logic [LW-1:0] MAXL = LW'(MAX_FRAME);

  logic          prev_q;
  logic [LW-1:0] cnt_q, len_q;
  logic [LW-1:0] len_new, len_eff, cnt_eff;
  logic          prev_eff, accept, eof;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;
  assign len_new  = (frame_len == '0 || frame_len > MAXL) ? MAXL : frame_len;
  assign len_eff  = frame_start ? len_new : len_q;
  assign cnt_eff  = frame_start ? '0 : cnt_q;
  assign prev_eff = frame_start ? 1'b0 : prev_q;
  assign eof      = (cnt_eff == len_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      cnt_q     <= '0;
      len_q     <= MAXL;
      out_valid <= 1'b0;
      out_sym   <= 2'b00;
      out_last  <= 1'b0;
    end else begin
      if (frame_start) begin
        len_q  <= len_new;
        cnt_q  <= '0;
        prev_q <= 1'b0;
      end
      if (accept) begin
        out_sym   <= {in_bit, ~(in_bit ^ prev_eff)};
        out_last  <= eof;
        prev_q    <= eof ? 1'b0 : in_bit;
        cnt_q     <= eof ? '0 : cnt_eff + 1'b1;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module trellis_half_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       in_valid,
  input logic       in_bit,
  input logic       in_ready,
  input logic       out_valid,
  input logic [1:0] out_sym,
  input logic       out_last,
  input logic       out_ready
);
  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_last));

  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  sym_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  systematic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_sym[1] == $past(in_bit));

  // R3
  first_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && frame_start |=> out_sym[1] != out_sym[0]);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind trellis_half_enc trellis_half_enc_chk u_chk (.*);

// File: tb/tb_trellis_half_enc.sv
module tb_trellis_half_enc;
  logic clk = 0, rst_n = 0, frame_start = 0, in_valid = 0, in_bit = 0, out_ready = 0;
  logic [10:0] frame_len = 0;
  logic in_ready, out_valid, out_last;
  logic [1:0] out_sym;

  trellis_half_enc dut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_len(frame_len), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_sym(out_sym), .out_last(out_last), .out_ready(out_ready));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic m_valid, m_last, m_prev;
  logic [1:0] m_sym;
  int m_cnt, m_len, m_kind;

  function automatic int clampb(input int l);
    return (l == 0 || l > 1200) ? 1200 : l;
  endfunction

  function automatic logic [1:0] enc(input logic b, input logic p);
    return {b, ~(b ^ p)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_last = 0; m_prev = 0; m_sym = 0; m_cnt = 0; m_len = 1200; m_kind = 3;
  endtask

  task automatic do_reset();
    rst_n = 0; frame_start = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; model_reset();
    #1;
    // R9
    chk(out_valid == 0, "R9", out_valid, 0);
    chk(in_ready == 1, "R9", in_ready, 1);
    @(negedge clk);
  endtask

  task automatic step(input logic fs, input int fl, input logic iv, input logic ib, input logic ordy);
    logic exp_ready, acc, p, eof;
    int c, l;
    frame_start = fs; frame_len = 11'(fl); in_valid = iv; in_bit = ib; out_ready = ordy;
    #1;
    exp_ready = !m_valid || ordy;
    chk(in_ready == exp_ready, "R8", in_ready, exp_ready);
    chk(out_valid == m_valid, "R1", out_valid, m_valid);
    if (m_valid) begin
      case (m_kind)
        3: chk(out_sym == m_sym, "R3", out_sym, m_sym);
        4: chk(out_sym == m_sym, "R4", out_sym, m_sym);
        default: chk(out_sym == m_sym, "R5", out_sym, m_sym);
      endcase
      chk(out_last == m_last, "R7", out_last, m_last);
    end
    acc = iv && exp_ready;
    p = fs ? 1'b0 : m_prev;
    c = fs ? 0 : m_cnt;
    l = fs ? clampb(fl) : m_len;
    if (fs) begin m_len = clampb(fl); m_cnt = 0; m_prev = 0; end
    if (acc) begin
      m_sym = enc(ib, p);
      m_kind = (c == 0) ? 3 : (p ? 5 : 4);
      eof = (c == l - 1);
      m_last = eof;
      m_prev = eof ? 1'b0 : ib;
      m_cnt = eof ? 0 : c + 1;
      m_valid = 1;
    end else if (ordy) m_valid = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat = 8'b10011001;
    logic [15:0] expv = 16'b1000011011000110;
    int lastcnt;
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();

    // R6 sample pattern with frame start on the first bit, length 8 (R7)
    for (int i = 0; i < 8; i++) begin
      step(i == 0, 8, 1, pat[7-i], 1);
      chk(out_sym == expv[15-2*i -: 2], "R6", out_sym, expv[15-2*i -: 2]);
      chk(out_last == (i == 7), "R7", out_last, i == 7);
    end
    step(0, 0, 0, 0, 1);

    // R8 stall: bits offered while output is held must be ignored
    step(1, 5, 1, 1, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, i[0], 0);
      chk(out_sym == 2'b10, "R8", out_sym, 2);
    end
    step(0, 0, 1, 1, 1);
    chk(out_sym == 2'b11, "R5", out_sym, 3);
    step(0, 0, 1, 0, 1);
    chk(out_sym == 2'b00, "R5", out_sym, 0);
    step(0, 0, 1, 0, 1);
    chk(out_sym == 2'b01, "R4", out_sym, 1);

    // R6 frame start without a bit, then a 1 after previous 0 -> 10 is first-state too
    step(0, 0, 1, 1, 1);
    step(1, 3, 0, 0, 1);
    step(0, 0, 1, 0, 1);
    chk(out_sym == 2'b01, "R6", out_sym, 1);

    // R9 default 1200 after reset, and R7 zero length selects 1200
    do_reset();
    lastcnt = 0;
    for (int i = 0; i < 1201; i++) begin
      step(0, 0, 1, 1'($urandom), 1);
      if (out_last) lastcnt++;
      if (i == 1199) chk(out_last == 1, "R9", out_last, 1);
    end
    chk(lastcnt == 1, "R7", lastcnt, 1);
    lastcnt = 0;
    for (int i = 0; i < 1200; i++) begin
      step(i == 0, 0, 1, 1'($urandom), 1);
      if (out_last) lastcnt++;
    end
    chk(lastcnt == 1 && out_last == 1, "R7", lastcnt, 1);

    // random mix: R1..R8
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 99);
      int fl = (r < 5) ? 1500 : $urandom_range(0, 9);
      step($urandom_range(0, 99) < 4, fl, $urandom_range(0, 99) < 70,
           1'($urandom), $urandom_range(0, 99) < 70);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule